// File: doc/BRIEF.md
# Configurable SPI Slave Word Shifter

This block is the slave end of a four-wire SPI link. It runs entirely on the system clock. It passes the serial clock, the data-in line and the active-low select through synchronizers and then finds the serial clock edges in the system-clock domain. The word length is a parameter. The clock idle level and the sampling phase are inputs, so any of the four SPI clock modes can be chosen between frames. The serial output is driven as a data bit together with an enable for the pad driver. Several slaves can therefore share one return line.

Local logic offers a word on a parallel input, and the block captures it when the select line falls. Each received word appears on a parallel output with a one-cycle valid strobe. A runtime mode input decides what happens once a word is complete. In single-word mode the block ignores all later clocks in that frame. In chain mode it keeps shifting, and each received word becomes the next outgoing word, so slaves wired in series pass data along the chain. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_slave_xfer`

## Requirements
- R1: `miso_en` is 0 two system clocks after `ss_n_pin` goes high and stays 0 while it is high. It is 1 two system clocks after `ss_n_pin` goes low and stays 1 while the pin is low.
- R2: The idle level of the serial clock is `cfg_cpol`. With `cfg_cpha`=0 the block samples on the idle-to-active edge and drives on the active-to-idle edge. With `cfg_cpha`=1 it drives on the idle-to-active edge and samples on the active-to-idle edge.
- R3: Bits travel MSB first in both directions. Every sampling clock moves one bit in and one bit out. After WORD_W clocks, `rx_word` holds the `mosi_pin` bits, with the first bit in bit WORD_W-1, and the master has received `tx_word`.
- R4: `tx_word` is captured when the select falls. Changing `tx_word` later in the frame does not change the bits on `miso_data`.
- R5: With `cfg_cpha`=0, the MSB of the captured word is on `miso_data` before the first serial clock edge.
- R6: `rx_valid` is a single-cycle pulse, once for each completed word. After reset, `rx_valid` is 0, `rx_word` is 0 and `miso_en` is 0.
- R7: With `cfg_chain`=0, the block ignores every clock after the WORD_W-th in the frame. No further `rx_valid` pulse occurs, `rx_word` keeps its value, and `miso_data` holds the last bit sent.
- R8: With `cfg_chain`=1, the block keeps shifting while selected. The word received during one group of WORD_W clocks is sent MSB first during the next group, and every group raises `rx_valid`.
- R9: The value of `cfg_chain` when a word completes decides whether the frame continues or stops, so the mode can change in the middle of a frame.
- R10: If the select rises before a word is complete, the partial word produces no `rx_valid`. The next frame starts again at its first bit with a freshly captured `tx_word`.
- R11: Serial clock and data activity while `ss_n_pin` is high produces no `rx_valid` and does not change the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_chain | input | 1 | 1: keep shifting past a word; 0: ignore extra clocks |
| sclk_pin | input | 1 | Serial clock from the master |
| mosi_pin | input | 1 | Serial data from the master |
| ss_n_pin | input | 1 | Active-low slave select |
| miso_data | output | 1 | Serial data bit to the master |
| miso_en | output | 1 | Output enable for the shared return line |
| tx_word | input | WORD_W | Word to send, captured at select |
| rx_word | output | WORD_W | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe when a word completes |

## Verification
The hardest case to reach from the ports is a change of `cfg_chain` that lands in the middle of the second word of a chained frame. The block must then finish that word, report it, and stop, while the return line keeps the last bit of the forwarded word. The bench reaches this case by running a three-word frame as a master in one thread. A parallel thread counts system clocks to a point inside the second word and clears the mode there. A model of the oversampled select, updated every clock, checks the output enable throughout. Aborted frames and clocking while deselected are placed just before complete frames, so any leftover state would show up in the next word.

// File: rtl/spi_sl_pkg.sv
package spi_sl_pkg;

  // Serial clock events seen in the system clock domain.
  typedef struct packed {
    logic sample;
    logic shift;
    logic start;
  } spi_ev_t;

  // Edge on which data is sampled: rising when polarity and phase agree.
  function automatic logic sample_on_rise(input logic cpol, input logic cpha);
    return ~(cpol ^ cpha);
  endfunction

  // Bit counter width for a given word length.
  function automatic int cnt_width(input int word_w);
    return (word_w > 2) ? $clog2(word_w) : 1;
  endfunction

endpackage

// File: rtl/spi_sl_sync.sv
module spi_sl_sync #(
  parameter int          WIDTH     = 3,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RESET_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RESET_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sl_edge.sv
module spi_sl_edge
  import spi_sl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ss_s,
  input  logic    sclk_s,
  input  logic    cpol,
  input  logic    cpha,
  output spi_ev_t ev
);
  logic sclk_q;
  logic ss_q;
  logic rise, fall, selected, on_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_s;
    end
  end

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign selected = ~ss_s;
  assign on_rise  = sample_on_rise(cpol, cpha);

  always_comb begin
    ev.sample = selected & (on_rise ? rise : fall);
    ev.shift  = selected & (on_rise ? fall : rise);
    ev.start  = ss_q & ~ss_s;
  end
endmodule

// File: rtl/spi_sl_rx.sv
module spi_sl_rx
  import spi_sl_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              sample_ev,
  input  logic              mosi_s,
  input  logic              chain_en,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld,
  output logic              at_wrap,
  output logic              fresh,
  output logic              halted
);
  localparam int CNT_W = cnt_width(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] next_word;

  assign next_word = {acc[WORD_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      acc      <= '0;
      word_q   <= '0;
      word_vld <= 1'b0;
      fresh    <= 1'b1;
      halted   <= 1'b0;
    end else if (start_ev) begin
      cnt      <= '0;
      fresh    <= 1'b1;
      halted   <= 1'b0;
      word_vld <= 1'b0;
    end else if (sample_ev && !halted) begin
      acc   <= next_word;
      fresh <= 1'b0;
      if (cnt == LAST) begin
        cnt      <= '0;
        word_q   <= next_word;
        word_vld <= 1'b1;
        halted   <= ~chain_en;
      end else begin
        cnt      <= cnt + 1'b1;
        word_vld <= 1'b0;
      end
    end else begin
      word_vld <= 1'b0;
    end
  end

  assign at_wrap = (cnt == '0);
endmodule

// File: rtl/spi_sl_tx.sv
module spi_sl_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              shift_ev,
  input  logic              halted,
  input  logic              at_wrap,
  input  logic              fresh,
  input  logic [WORD_W-1:0] load_first,
  input  logic [WORD_W-1:0] load_next,
  output logic              out_bit
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (start_ev) begin
      sh <= load_first;
    end else if (shift_ev && !halted) begin
      if (at_wrap) begin
        if (!fresh) sh <= load_next;
      end else begin
        sh <= {sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign out_bit = sh[WORD_W-1];
endmodule

// File: rtl/spi_slave_xfer.sv
module spi_slave_xfer
  import spi_sl_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_chain,
  input  logic              sclk_pin,
  input  logic              mosi_pin,
  input  logic              ss_n_pin,
  output logic              miso_data,
  output logic              miso_en,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] pins_s;
  logic              ss_sync, sclk_sync, mosi_sync;
  spi_ev_t           ev;
  logic              sample_ev, shift_ev, start_ev;
  logic              at_wrap, fresh, halted;

  spi_sl_sync #(
    .WIDTH    (SYNC_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ss_n_pin, sclk_pin, mosi_pin}),
    .q    (pins_s)
  );

  assign ss_sync   = pins_s[2];
  assign sclk_sync = pins_s[1];
  assign mosi_sync = pins_s[0];

  spi_sl_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ss_s  (ss_sync),
    .sclk_s(sclk_sync),
    .cpol  (cfg_cpol),
    .cpha  (cfg_cpha),
    .ev    (ev)
  );

  assign sample_ev = ev.sample;
  assign shift_ev  = ev.shift;
  assign start_ev  = ev.start;

  spi_sl_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .sample_ev(sample_ev),
    .mosi_s   (mosi_sync),
    .chain_en (cfg_chain),
    .word_q   (rx_word),
    .word_vld (rx_valid),
    .at_wrap  (at_wrap),
    .fresh    (fresh),
    .halted   (halted)
  );

  spi_sl_tx #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ev  (start_ev),
    .shift_ev  (shift_ev),
    .halted    (halted),
    .at_wrap   (at_wrap),
    .fresh     (fresh),
    .load_first(tx_word),
    .load_next (rx_word),
    .out_bit   (miso_data)
  );

  assign miso_en = ~ss_sync;
endmodule

// File: rtl/spi_slave_xfer_chk.sv
module spi_slave_xfer_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n_pin,
  input logic [WORD_W-1:0] tx_word,
  input logic              miso_data,
  input logic              miso_en,
  input logic              rx_valid,
  input logic              sample_ev,
  input logic              shift_ev,
  input logic              start_ev,
  input logic              halted
);
  AST_EN_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_pin && $past(ss_n_pin) && $past(ss_n_pin, 2) |-> !miso_en); // R1

  AST_EN_ON_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n_pin && !$past(ss_n_pin) && !$past(ss_n_pin, 2) |-> miso_en); // R1

  AST_LOAD_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> miso_data == $past(tx_word[WORD_W-1])); // R4

  AST_OUT_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev && !shift_ev |=> $stable(miso_data)); // R2

  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample_ev)); // R6

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R6

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted && $past(halted) |-> !rx_valid); // R7
endmodule

bind spi_slave_xfer spi_slave_xfer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ss_n_pin (ss_n_pin),
  .tx_word  (tx_word),
  .miso_data(miso_data),
  .miso_en  (miso_en),
  .rx_valid (rx_valid),
  .sample_ev(sample_ev),
  .shift_ev (shift_ev),
  .start_ev (start_ev),
  .halted   (halted)
);

// File: tb/spi_slave_xfer_bench.sv
`timescale 1ns/1ps
module spi_slave_xfer_bench;
  localparam int W    = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, chain = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic miso_data, miso_en;
  logic [W-1:0] tx_word = '0;
  logic [W-1:0] rx_word;
  logic rx_valid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] rxq[$];
  logic [1:0] ss_hist = 2'b11;

  always #2.5 clk = ~clk;

  spi_slave_xfer #(.WORD_W(W)) u_spi_slave_xfer (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_chain(chain),
    .sclk_pin(sclk), .mosi_pin(mosi), .ss_n_pin(ss_n),
    .miso_data(miso_data), .miso_en(miso_en),
    .tx_word(tx_word), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Select synchronizer model, compared every clock (R1)
  always @(posedge clk) ss_hist <= {ss_hist[0], ss_n};
  always @(negedge clk) begin
    if (rst_n) chk(miso_en == !ss_hist[1], "R1 enable", 64'(miso_en), 64'(!ss_hist[1]));
    if (rst_n && rx_valid) rxq.push_back(rx_word);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master: bit i of the frame is mv[63-i]; captured bits go to mi[63-i].
  task automatic run_frame(input logic pol, input logic ph, input int nbits,
                           input logic [63:0] mv, input logic [W-1:0] tx_first,
                           input logic [W-1:0] tx_after, output logic [63:0] mi);
    mi = '0;
    cpol = pol; cpha = ph; sclk = pol;
    tx_word = tx_first;
    if (!ph) mosi = mv[63];
    tick(HALF);
    ss_n = 1'b0;
    tick(HALF);
    tx_word = tx_after;
    for (int i = 0; i < nbits; i++) begin
      if (ph) begin
        sclk = ~pol; mosi = mv[63-i];
        tick(HALF);
        mi[63-i] = miso_data;
        sclk = pol;
        tick(HALF);
      end else begin
        mi[63-i] = miso_data;
        sclk = ~pol;
        tick(HALF);
        sclk = pol;
        if (i + 1 < nbits) mosi = mv[63-(i+1)];
        tick(HALF);
      end
    end
    ss_n = 1'b1;
    tick(2*HALF);
  endtask

  function automatic logic [63:0] exp_miso(input logic [W-1:0] tx, input logic [63:0] mv,
                                           input int nbits, input int act_words);
    logic [63:0] r = '0;
    for (int i = 0; i < nbits; i++) begin
      int k = i / W;
      int j = i % W;
      if (k >= act_words) begin k = act_words - 1; j = W - 1; end
      r[63-i] = (k == 0) ? tx[W-1-j] : mv[63-((k-1)*W + j)];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [63:0] mv, input int k);
    return mv[63-k*W -: W];
  endfunction

  task automatic check_words(input string req, input logic [63:0] mv, input int nwords);
    chk(rxq.size() == nwords, req, 64'(rxq.size()), 64'(nwords));
    for (int k = 0; k < nwords && k < rxq.size(); k++)
      chk(rxq[k] == exp_word(mv, k), req, 64'(rxq[k]), 64'(exp_word(mv, k)));
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] mi, mv;
    logic [W-1:0] tx;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk(miso_en == 1'b0, "R6 reset enable", 64'(miso_en), 64'(0));
    chk(rx_valid == 1'b0, "R6 reset valid", 64'(rx_valid), 64'(0));
    chk(rx_word == '0, "R6 reset word", 64'(rx_word), 64'(0));

    // R2 R3 R4 R5: one word in each clock mode, tx_word changed after select
    for (int m = 0; m < 4; m++) begin
      tx = W'(8'hB4 ^ (m * 8'h27));
      mv = 64'h6D00_0000_0000_0000 ^ (64'(m) << 60);
      chain = 1'b0;
      rxq.delete();
      run_frame(m[1], m[0], W, mv, tx, ~tx, mi);
      chk(mi == exp_miso(tx, mv, W, 1), m[0] ? "R2 R3 R4 miso" : "R5 R3 R4 miso",
          mi, exp_miso(tx, mv, W, 1));
      check_words("R3 R6 rx", mv, 1);
    end

    // R7: extra clocks ignored in single-word mode
    for (int m = 0; m < 2; m++) begin
      tx = m ? 8'h3B : 8'hC6;
      mv = 64'h9A5F_0000_0000_0000;
      rxq.delete();
      run_frame(m[0], m[0], W + 5, mv, tx, tx, mi);
      chk(mi == exp_miso(tx, mv, W + 5, 1), "R7 miso hold", mi, exp_miso(tx, mv, W + 5, 1));
      check_words("R7 single word", mv, 1);
      chk(rx_word == exp_word(mv, 0), "R7 word kept", 64'(rx_word), 64'(exp_word(mv, 0)));
    end

    // R8: chain mode forwards each word in the next group
    chain = 1'b1;
    tx = 8'h81;
    mv = 64'h5C_E7_2B_00_0000_0000;
    rxq.delete();
    run_frame(1'b0, 1'b1, 3*W, mv, tx, 8'h00, mi);
    chk(mi == exp_miso(tx, mv, 3*W, 99), "R8 chain cpha1", mi, exp_miso(tx, mv, 3*W, 99));
    check_words("R8 chain words", mv, 3);
    tx = 8'h7E;
    mv = 64'hA3_1D_00_00_0000_0000;
    rxq.delete();
    run_frame(1'b1, 1'b0, 2*W, mv, tx, 8'hFF, mi);
    chk(mi == exp_miso(tx, mv, 2*W, 99), "R8 chain cpha0", mi, exp_miso(tx, mv, 2*W, 99));
    check_words("R8 chain words 2", mv, 2);

    // R9: mode cleared during the second word stops the frame after it
    chain = 1'b1;
    tx = 8'hD2;
    mv = 64'h4F_96_3C_00_0000_0000;
    rxq.delete();
    fork
      run_frame(1'b0, 1'b0, 3*W, mv, tx, tx, mi);
      begin tick(25*HALF); chain = 1'b0; end
    join
    chk(mi == exp_miso(tx, mv, 3*W, 2), "R9 switch miso", mi, exp_miso(tx, mv, 3*W, 2));
    check_words("R9 switch words", mv, 2);
    chain = 1'b0;

    // R10: aborted frame, then a full one
    rxq.delete();
    run_frame(1'b0, 1'b1, 5, 64'hF800_0000_0000_0000, 8'h55, 8'h55, mi);
    chk(rxq.size() == 0, "R10 no valid on abort", 64'(rxq.size()), 64'(0));
    mv = 64'h2E00_0000_0000_0000;
    run_frame(1'b0, 1'b1, W, mv, 8'hA9, 8'hA9, mi);
    chk(mi == exp_miso(8'hA9, mv, W, 1), "R10 restart miso", mi, exp_miso(8'hA9, mv, W, 1));
    check_words("R10 restart word", mv, 1);

    // R11: activity while deselected has no effect
    rxq.delete();
    cpol = 1'b0; cpha = 1'b0;
    for (int i = 0; i < 12; i++) begin
      sclk = ~sclk; mosi = i[1];
      tick(HALF);
    end
    sclk = 1'b0;
    tick(HALF);
    chk(rxq.size() == 0, "R11 no valid deselected", 64'(rxq.size()), 64'(0));
    chk(miso_en == 1'b0, "R11 enable off", 64'(miso_en), 64'(0));
    mv = 64'hC100_0000_0000_0000;
    run_frame(1'b0, 1'b0, W, mv, 8'h96, 8'h96, mi);
    chk(mi == exp_miso(8'h96, mv, W, 1), "R11 next frame miso", mi, exp_miso(8'h96, mv, W, 1));
    check_words("R11 next frame word", mv, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule